// File: doc/BRIEF.md
# Dual-Edge Data Block Receiver

This block receives one fixed-size data block from a 4-line or 8-line data bus that carries its payload on both clock edges. A block opens with a start bit that lasts a full clock period. The payload follows on every rising and every falling edge. Each active line then carries two 16-bit CRCs, one per edge polarity, also on both edges. A full-period end bit closes the block. Rising-edge samples carry the odd-numbered bytes (1st, 3rd, … 511th). Falling-edge samples carry the even-numbered bytes (2nd, 4th, … 512th).

The receiver samples every rising edge in one flop and every falling edge in another. It handles each rising/falling sample pair on the following rising clock edge. Inside the core everything runs at single rate. Bytes come out as odd/even pairs in their original order, so two payload bytes arrive per output strobe. When the block ends, a one-cycle done pulse is raised, and an error flag records any CRC mismatch or a missing end bit. A new block may start on the rising edge right after an end bit.

Top module: `ddrBlockRx`

## Requirements
- R1: While reset is asserted, and after release until a block completes, `outValid`, `blockDone` and `crcErr` are low.
- R2: While idle, a block starts only when line 0 is sampled low on a rising edge. Lines 1 to 7 low with line 0 high start nothing, and no output strobe occurs.
- R3: Width select = 1 (8 lines): on each payload rising edge, line i carries bit i of an odd byte. On the falling edge that follows, line i carries bit i of the next even byte. `outPair[7:0]` is the odd byte and `outPair[15:8]` the even byte. `outValid` pulses once per clock period.
- R4: Width select = 0 (4 lines, lines 3:0): an odd byte uses two successive rising edges and its even partner uses the two falling edges in between. Bits 7:4 come first, then bits 3:0. A pair is emitted every second clock.
- R5: A block always holds 512 bytes, so exactly 256 `outValid` pulses occur per block in either width.
- R6: After the payload come 16 clock periods in which each active line sends, on both edges, a CRC16 (polynomial 0x1021, zero initial value, MSB first). The rising-edge CRC covers that line's rising-edge payload bits. The falling-edge CRC covers its falling-edge payload bits. Any mismatch gives `crcErr`=1 at `blockDone`.
- R7: The rising edge after the CRC period carries the end bit. If any active line is low there, `crcErr`=1 at `blockDone`.
- R8: `blockDone` is a one-cycle pulse on the clock after the rising edge that carries the end bit. `crcErr` is updated together with it and holds until the next `blockDone`.
- R9: Width select is taken on the rising edge that carries the first payload bits. Later changes within the block have no effect.
- R10: In 4-line mode, lines 7:4 are ignored entirely: their data, CRC and end-bit values change neither the bytes nor `crcErr`.
- R11: After an end bit the receiver is idle again and accepts a start bit on the very next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; both edges carry payload |
| rstN | input | 1 | Asynchronous reset, active low |
| datIn | input | 8 | Data lines |
| wideSel | input | 1 | 1 = 8 active lines, 0 = 4 active lines |
| outPair | output | 16 | Odd byte in [7:0], following even byte in [15:8] |
| outValid | output | 1 | `outPair` holds a new byte pair |
| blockDone | output | 1 | One-cycle pulse when the end bit has been checked |
| crcErr | output | 1 | Error result of the last completed block |

## Verification
The hardest situations to reach from the ports are the ones where one 16-bit check word on one line and one edge polarity is wrong, while everything around it is right. The bench therefore computes both CRCs of every line from its own byte list and flips a single bit in one chosen word: a falling-edge word on an upper line in 8-line mode, and a rising-edge word in 4-line mode. It also corrupts an inactive upper line in 4-line mode, where the result must stay clean. Mid-block width changes and a start bit on the edge right after an end bit are driven directly by the bench's per-cycle bus driver.

// File: rtl/ddrRxPkg.sv
package ddrRxPkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_CRC,
    ST_END
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // hold CRC registers at zero
    logic feed;    // advance CRC registers by one bit per edge
    logic capHi;   // store high nibbles (narrow mode)
    logic emit;    // produce a byte pair
    logic check;   // evaluate the end bit and CRC residues
    logic wide8;   // latched width of the current block
  } rxStb_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/ddrRxCtl.sv
module ddrRxCtl
  import ddrRxPkg::*;
#(
  parameter int BLOCK_BYTES = 512
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startSeen,
  input  logic   wideSel,
  output rxStb_t stb
);

  localparam int PAIRS = BLOCK_BYTES / 2;
  localparam int CNT_W = $clog2(BLOCK_BYTES);

  rxState_t   state;
  logic [CNT_W-1:0] cnt;
  logic       modeWide;
  logic       dataLast;
  logic       crcLast;

  assign dataLast = modeWide ? (cnt == CNT_W'(PAIRS - 1)) : (cnt == CNT_W'(BLOCK_BYTES - 1));
  assign crcLast  = (cnt == CNT_W'(CRC_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      modeWide <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (startSeen) begin
            state    <= ST_DATA;
            modeWide <= wideSel;
          end
        end
        ST_DATA: begin
          if (dataLast) begin
            cnt   <= '0;
            state <= ST_CRC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CRC: begin
          if (crcLast) begin
            cnt   <= '0;
            state <= ST_END;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_END: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb       = '0;
    stb.wide8 = modeWide;
    stb.clear = (state == ST_IDLE);
    stb.feed  = (state == ST_DATA) || (state == ST_CRC);
    stb.capHi = (state == ST_DATA) && !modeWide && !cnt[0];
    stb.emit  = (state == ST_DATA) && (modeWide || cnt[0]);
    stb.check = (state == ST_END);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !(stb.emit || stb.feed || stb.check)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capHi, stb.emit, stb.check})); // R4

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(modeWide)); // R9

  AST_BACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.check |=> (state == ST_IDLE)); // R11

endmodule

// File: rtl/ddrRxPath.sv
module ddrRxPath
  import ddrRxPkg::*;
#(
  parameter int LINES       = 8,
  parameter int BLOCK_BYTES = 512
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES-1:0]   datIn,
  input  rxStb_t             stb,
  output logic               startSeen,
  output logic [2*LINES-1:0] outPair,
  output logic               outValid,
  output logic               blockDone,
  output logic               crcErr
);

  localparam int NARROW = LINES / 2;
  localparam int PAIRS  = BLOCK_BYTES / 2;
  localparam int PCNT_W = $clog2(PAIRS + 1);

  logic [LINES-1:0]  riseReg, fallReg;
  logic [LINES-1:0]  residRise, residFall;
  logic [LINES-1:0]  activeMask;
  logic [NARROW-1:0] hiRise, hiFall;
  logic [LINES-1:0]  oddByte, evenByte;
  logic              blockBad;

  // rising-edge sample, paired with the falling-edge sample that follows it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) riseReg <= '1;
    else       riseReg <= datIn;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fallReg <= '1;
    else       fallReg <= datIn;
  end

  assign startSeen = ~riseReg[0];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [CRC_W-1:0] crcRise, crcFall;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        crcRise <= '0;
        crcFall <= '0;
      end else if (stb.clear) begin
        crcRise <= '0;
        crcFall <= '0;
      end else if (stb.feed) begin
        crcRise <= crcStep(crcRise, riseReg[l]);
        crcFall <= crcStep(crcFall, fallReg[l]);
      end
    end
    assign residRise[l] = |crcRise;
    assign residFall[l] = |crcFall;
  end

  assign activeMask = stb.wide8 ? '1 : {{(LINES-NARROW){1'b0}}, {NARROW{1'b1}}};
  assign blockBad   = (|((residRise | residFall) & activeMask)) | (|(~riseReg & activeMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRise <= '0;
      hiFall <= '0;
    end else if (stb.capHi) begin
      hiRise <= riseReg[NARROW-1:0];
      hiFall <= fallReg[NARROW-1:0];
    end
  end

  assign oddByte  = stb.wide8 ? riseReg : {hiRise, riseReg[NARROW-1:0]};
  assign evenByte = stb.wide8 ? fallReg : {hiFall, fallReg[NARROW-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outPair   <= '0;
      outValid  <= 1'b0;
      blockDone <= 1'b0;
      crcErr    <= 1'b0;
    end else begin
      outValid  <= stb.emit;
      blockDone <= stb.check;
      if (stb.emit)  outPair <= {evenByte, oddByte};
      if (stb.check) crcErr  <= blockBad;
    end
  end

  // pair counter kept only for the checks below
  logic [PCNT_W-1:0] emitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          emitCnt <= '0;
    else if (stb.clear) emitCnt <= '0;
    else if (stb.emit)  emitCnt <= emitCnt + 1'b1;
  end

  AST_PAIR_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    stb.check |-> (emitCnt == PCNT_W'(PAIRS))); // R5

  AST_EMIT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    stb.emit |=> outValid); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> !blockDone); // R8

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !blockDone |-> $stable(crcErr)); // R8

endmodule

// File: rtl/ddrBlockRx.sv
module ddrBlockRx
  import ddrRxPkg::*;
#(
  parameter int LINES       = 8,
  parameter int BLOCK_BYTES = 512
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINES-1:0]   datIn,
  input  logic               wideSel,
  output logic [2*LINES-1:0] outPair,
  output logic               outValid,
  output logic               blockDone,
  output logic               crcErr
);

  rxStb_t stb;
  logic   startSeen;

  ddrRxCtl #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startSeen (startSeen),
    .wideSel   (wideSel),
    .stb       (stb)
  );

  ddrRxPath #(.LINES(LINES), .BLOCK_BYTES(BLOCK_BYTES)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .datIn     (datIn),
    .stb       (stb),
    .startSeen (startSeen),
    .outPair   (outPair),
    .outValid  (outValid),
    .blockDone (blockDone),
    .crcErr    (crcErr)
  );

endmodule

// File: tb/ddrBlockRx_tb.sv
module ddrBlockRx_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  datIn = 8'hFF;
  logic        wideSel = 1'b1;
  logic [15:0] outPair;
  logic        outValid, blockDone, crcErr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int pairsInBlk = 0;
  int validSeen = 0;
  int doneSeen = 0;
  bit monOn = 0;

  logic [16:0] pairQ[$];
  bit          errQ[$];
  int          cycQ[$];
  string       tagQ[$];

  logic [7:0] rv[512];
  logic [7:0] fv[512];

  ddrBlockRx u_dut (
    .clk(clk), .rstN(rstN), .datIn(datIn), .wideSel(wideSel),
    .outPair(outPair), .outValid(outValid), .blockDone(blockDone), .crcErr(crcErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stepCrc(input logic [15:0] c, input logic b);
    logic [15:0] n;
    n = c << 1;
    if (c[15] != b) n = n ^ 16'h1021;
    return n;
  endfunction

  // one bus clock: r is sampled on the rising edge, f on the falling edge
  task automatic drv(input logic [7:0] r, input logic [7:0] f);
    @(negedge clk);
    #1 datIn = r;
    @(posedge clk);
    #1 datIn = f;
  endtask

  task automatic sendBlock(input bit w8, input bit randPat, input int errLine, input bit errFall,
                           input bit badEnd, input bit flipW, input bit expErr, input int gap,
                           input string tag);
    logic [7:0]  bytes[512];
    logic [15:0] cr[8];
    logic [15:0] cf[8];
    logic [7:0]  r, f;
    logic [3:0]  junk;
    int nCyc;
    int endCyc;
    nCyc = w8 ? 256 : 512;
    for (int i = 0; i < 512; i++) bytes[i] = randPat ? 8'($urandom) : 8'(i * 3 + 1);
    for (int j = 0; j < 256; j++) pairQ.push_back({w8, bytes[2*j+1], bytes[2*j]});
    for (int c = 0; c < nCyc; c++) begin
      if (w8) begin
        rv[c] = bytes[2*c];
        fv[c] = bytes[2*c+1];
      end else begin
        junk = 4'($urandom);
        rv[c] = {junk, (c % 2 == 0) ? bytes[c-(c%2)][7:4] : bytes[c-(c%2)][3:0]};
        junk = 4'($urandom);
        fv[c] = {junk, (c % 2 == 0) ? bytes[c-(c%2)+1][7:4] : bytes[c-(c%2)+1][3:0]};
      end
    end
    for (int l = 0; l < 8; l++) begin
      cr[l] = '0;
      cf[l] = '0;
      for (int c = 0; c < nCyc; c++) begin
        cr[l] = stepCrc(cr[l], rv[c][l]);
        cf[l] = stepCrc(cf[l], fv[c][l]);
      end
    end
    if (errLine >= 0) begin
      if (errFall) cf[errLine] = cf[errLine] ^ 16'h0100;
      else         cr[errLine] = cr[errLine] ^ 16'h0100;
    end
    errQ.push_back(expErr);
    tagQ.push_back(tag);
    wideSel = w8;
    junk = 4'($urandom);
    drv(w8 ? 8'h00 : {junk, 4'h0}, w8 ? 8'h00 : {junk, 4'h0});
    for (int c = 0; c < nCyc; c++) begin
      drv(rv[c], fv[c]);
      if (c == 0 && flipW) wideSel = ~w8;
    end
    for (int b = 0; b < 16; b++) begin
      for (int l = 0; l < 8; l++) begin
        r[l] = cr[l][15-b];
        f[l] = cf[l][15-b];
      end
      drv(r, f);
    end
    junk = 4'($urandom);
    r = badEnd ? 8'h7F : (w8 ? 8'hFF : {junk, 4'hF});
    @(negedge clk);
    endCyc = cyc;
    cycQ.push_back(endCyc + 2);
    #1 datIn = r;
    @(posedge clk);
    #1 datIn = r;
    wideSel = w8;
    for (int g = 0; g < gap; g++) drv(8'hFF, 8'hFF);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (outValid) begin
        logic [16:0] e;
        validSeen++;
        pairsInBlk++;
        if (pairQ.size() == 0) begin
          check(0, "R2 unexpected pair", outPair, 0);
        end else begin
          e = pairQ.pop_front();
          check(outPair == e[15:0], e[16] ? "R3 pair in 8-line mode" : "R4 pair in 4-line mode",
                outPair, e[15:0]);
        end
      end
      if (blockDone) begin
        doneSeen++;
        if (errQ.size() == 0) begin
          check(0, "R2 unexpected blockDone", 1, 0);
        end else begin
          string t;
          bit ee;
          int ec;
          t  = tagQ.pop_front();
          ee = errQ.pop_front();
          ec = cycQ.pop_front();
          check(crcErr == ee, {t, " error flag R6 R7"}, crcErr, ee);
          check(cyc == ec, {t, " done timing R8"}, cyc, ec);
          check(pairsInBlk == 256, {t, " pair count R5"}, pairsInBlk, 256);
        end
        pairsInBlk = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v0, d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({outValid, blockDone, crcErr} == 3'b000, "R1 outputs in reset", {outValid, blockDone, crcErr}, 0);
    rstN = 1'b1;
    monOn = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({outValid, blockDone, crcErr} == 3'b000, "R1 outputs after reset", {outValid, blockDone, crcErr}, 0);

    // R2: upper lines low, line 0 high: no block
    v0 = validSeen; d0 = doneSeen;
    repeat (40) drv(8'h01, 8'h01);
    repeat (3) drv(8'hFF, 8'hFF);
    check(validSeen == v0 && doneSeen == d0, "R2 no start without line 0", validSeen - v0 + doneSeen - d0, 0);

    sendBlock(1, 0, -1, 0, 0, 0, 0, 3, "R3 wide count pattern");
    sendBlock(1, 1, -1, 0, 0, 0, 0, 3, "R3 wide random");
    sendBlock(0, 1, -1, 0, 0, 0, 0, 3, "R4 R10 narrow random, junk upper lines");
    sendBlock(1, 1, 5, 1, 0, 0, 1, 3, "R6 wide falling CRC line 5 bad");

    // R8: flag holds through idle
    repeat (20) drv(8'hFF, 8'hFF);
    @(negedge clk);
    check(crcErr == 1'b1, "R8 crcErr held while idle", crcErr, 1);

    sendBlock(1, 1, -1, 0, 0, 0, 0, 3, "R8 clean block clears flag");
    sendBlock(0, 1, 2, 0, 0, 0, 1, 3, "R6 narrow rising CRC line 2 bad");
    sendBlock(0, 1, 6, 1, 0, 0, 0, 3, "R10 narrow inactive line 6 CRC bad");
    sendBlock(1, 1, -1, 0, 1, 0, 1, 3, "R7 wide end bit low on line 7");
    sendBlock(0, 1, -1, 0, 0, 1, 0, 3, "R9 narrow with width flip");
    sendBlock(1, 1, -1, 0, 0, 1, 0, 3, "R9 wide with width flip");
    sendBlock(1, 1, -1, 0, 0, 0, 0, 0, "R11 back-to-back first");
    sendBlock(0, 1, -1, 0, 0, 0, 0, 0, "R11 back-to-back second");
    sendBlock(1, 0, -1, 0, 0, 0, 0, 0, "R11 back-to-back third");

    repeat (10) drv(8'hFF, 8'hFF);
    check(pairQ.size() == 0, "R5 all pairs delivered", pairQ.size(), 0);
    check(errQ.size() == 0, "R8 all blocks completed", errQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule